// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a virtual address into a physical address by reading a single entry from a one-level page table held in memory. A requester presents a virtual address and an access kind (load, store or instruction fetch) on a valid/ready port. The block computes where the entry sits from a writable table base, issues one read on a simple memory port and waits for the returned word. It then checks the entry's present bit and its permission bits for the access kind. It answers with either a physical address or a fault and a cause code.

Pages are 4 KiB. The low 12 address bits pass through unchanged, and the remaining upper bits select the entry. The table base is reloaded when the running process changes. Only one translation is in flight at a time. The block does not cache translations, does not walk several levels, and leaves fault handling to the requester.

Top module: `pt_xlate`

## Requirements
- R1: After reset `reqReady` is 1, and `rspValid` and `memReq` are 0.
- R2: An accepted request (`reqValid` and `reqReady` high at a clock edge) makes `memReq` high for exactly one cycle, in the next cycle. During that cycle `memAddr` equals table base + (virtual page number × 4), where the virtual page number is `reqVaddr[31:12]`.
- R3: A write with `baseWrEn` replaces the table base, and the new base is used by requests accepted afterwards. A base write made while a translation is in flight does not change that translation's entry address or its result.
- R4: The 32-bit entry is laid out as follows: bit 31 is present, bit 30 is read permission, bit 29 is write permission, bit 28 is execute permission, and bits 19:0 are the physical page number.
- R5: If the entry's present bit is 0, the response is a fault with cause 2'b01, whatever the permission bits are (absence takes priority over permission checks).
- R6: The access kind is encoded as 2'b00 load, 2'b01 store, 2'b10 fetch and 2'b11 reserved. A present entry faults with cause 2'b10 if a load lacks read permission, a store lacks write permission, or a fetch lacks execute permission. Kind 2'b11 always faults with cause 2'b10.
- R7: On success, `rspFault` is 0, `rspCause` is 2'b00 and `rspPaddr` is {page number, `reqVaddr[11:0]`}. On a fault, `rspPaddr` is 0.
- R8: `reqReady` is low from the cycle after acceptance until the response. `rspValid` is high for one cycle, starting the cycle after the memory word is taken, and `reqReady` is high again in the following cycle.
- R9: The memory word is taken on the first cycle with `memRespValid` high, at least one cycle after `memReq`. The block waits any number of cycles for it, with `reqReady` low and no further `memReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseWrEn | input | 1 | Load the table base |
| baseWrData | input | 32 | New table base byte address |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqKind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| memReq | output | 1 | One-cycle read strobe for the entry |
| memAddr | output | 32 | Byte address of the entry |
| memRespValid | input | 1 | Entry word returned |
| memRespData | input | 32 | Entry word |
| rspValid | output | 1 | Translation result present (one cycle) |
| rspPaddr | output | 32 | Physical address (0 on fault) |
| rspFault | output | 1 | Translation faulted |
| rspCause | output | 2 | 00 none, 01 not present, 10 permission |

## Verification
Each access kind is tried against entries whose permission bits grant it and against entries that withhold it. This shows that every kind consults only its own permission bit. Entries that are absent, both with no permissions and with every permission set, separate the absence cause from the permission cause and show which one wins. The reserved kind is also tried against a fully permissive entry. Memory latencies of one and several cycles, base reloads between requests and during a walk, and offsets and page numbers with all bits set exercise the handshake timing, the sampling of the base and the assembly of the physical address.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'b00,
    KIND_STORE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } accKind_e;

  localparam logic [1:0] CAUSE_NONE   = 2'b00;
  localparam logic [1:0] CAUSE_ABSENT = 2'b01;
  localparam logic [1:0] CAUSE_RIGHTS = 2'b10;

  localparam int ENTRY_W    = 32;
  localparam int ENTRY_PRES = 31;
  localparam int ENTRY_RD   = 30;
  localparam int ENTRY_WR   = 29;
  localparam int ENTRY_EX   = 28;
  localparam int ENTRY_SHIFT = 2;

  typedef struct packed {
    logic takeReq;
    logic issueRead;
    logic takeEntry;
    logic respond;
  } ctlStrobe_t;

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memRespValid,
  output logic       reqReady,
  output ctlStrobe_t strobe
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10,
    ST_RESP  = 2'b11
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (reqValid) stateNext = ST_ISSUE;
      ST_ISSUE: stateNext = ST_WAIT;
      ST_WAIT:  if (memRespValid) stateNext = ST_RESP;
      ST_RESP:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    reqReady          = (state == ST_IDLE);
    strobe.takeReq    = (state == ST_IDLE) && reqValid;
    strobe.issueRead  = (state == ST_ISSUE);
    strobe.takeEntry  = (state == ST_WAIT) && memRespValid;
    strobe.respond    = (state == ST_RESP);
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && strobe.issueRead)); // R2

  AST_SINGLE_READ_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueRead |=> !strobe.issueRead); // R9

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.respond |=> (!strobe.respond && reqReady)); // R8

  AST_RESP_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeEntry |=> strobe.respond); // R8

endmodule

// File: rtl/xlate_dpath.sv
module xlate_dpath
  import xlate_pkg::*;
#(
  parameter int VADDR_W = 32,
  parameter int PADDR_W = 32,
  parameter int OFS_W   = 12,
  parameter int BASE_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic               baseWrEn,
  input  logic [BASE_W-1:0]  baseWrData,
  input  logic [VADDR_W-1:0] reqVaddr,
  input  logic [1:0]         reqKind,
  input  logic [ENTRY_W-1:0] memRespData,
  output logic [BASE_W-1:0]  memAddr,
  output logic [PADDR_W-1:0] rspPaddr,
  output logic               rspFault,
  output logic [1:0]         rspCause
);

  localparam int VPN_W = VADDR_W - OFS_W;
  localparam int PPN_W = PADDR_W - OFS_W;

  logic [BASE_W-1:0]  baseReg;
  logic [BASE_W-1:0]  walkAddr;
  logic [OFS_W-1:0]   offsetReg;
  accKind_e           kindReg;
  logic [ENTRY_W-1:0] entryReg;
  logic [VPN_W-1:0]   reqVpn;
  logic [BASE_W-1:0]  entryOffset;

  assign reqVpn      = reqVaddr[VADDR_W-1:OFS_W];
  assign entryOffset = BASE_W'(reqVpn) << ENTRY_SHIFT;

  always_ff @(posedge clk) begin
    if (!rstN)         baseReg <= '0;
    else if (baseWrEn) baseReg <= baseWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkAddr  <= '0;
      offsetReg <= '0;
      kindReg   <= KIND_LOAD;
    end else if (strobe.takeReq) begin
      walkAddr  <= baseReg + entryOffset;
      offsetReg <= reqVaddr[OFS_W-1:0];
      kindReg   <= accKind_e'(reqKind);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 entryReg <= '0;
    else if (strobe.takeEntry) entryReg <= memRespData;
  end

  assign memAddr = walkAddr;

  logic present;
  logic permitted;

  always_comb begin
    present = entryReg[ENTRY_PRES];
    unique case (kindReg)
      KIND_LOAD:  permitted = entryReg[ENTRY_RD];
      KIND_STORE: permitted = entryReg[ENTRY_WR];
      KIND_FETCH: permitted = entryReg[ENTRY_EX];
      default:    permitted = 1'b0;
    endcase
  end

  always_comb begin
    if (!present) begin
      rspFault = 1'b1;
      rspCause = CAUSE_ABSENT;
      rspPaddr = '0;
    end else if (!permitted) begin
      rspFault = 1'b1;
      rspCause = CAUSE_RIGHTS;
      rspPaddr = '0;
    end else begin
      rspFault = 1'b0;
      rspCause = CAUSE_NONE;
      rspPaddr = {entryReg[PPN_W-1:0], offsetReg};
    end
  end

  AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.respond |-> (rspFault == (rspCause != CAUSE_NONE))); // R7

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.respond && rspFault) |-> (rspPaddr == '0)); // R7

  AST_WALK_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.takeReq && !$past(strobe.takeReq)) |-> $stable(walkAddr)); // R3

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import xlate_pkg::*;
#(
  parameter int VADDR_W = 32,
  parameter int PADDR_W = 32,
  parameter int OFS_W   = 12,
  parameter int BASE_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               baseWrEn,
  input  logic [BASE_W-1:0]  baseWrData,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [VADDR_W-1:0] reqVaddr,
  input  logic [1:0]         reqKind,
  output logic               memReq,
  output logic [BASE_W-1:0]  memAddr,
  input  logic               memRespValid,
  input  logic [31:0]        memRespData,
  output logic               rspValid,
  output logic [PADDR_W-1:0] rspPaddr,
  output logic               rspFault,
  output logic [1:0]         rspCause
);

  ctlStrobe_t strobe;

  xlate_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .memRespValid (memRespValid),
    .reqReady     (reqReady),
    .strobe       (strobe)
  );

  xlate_dpath #(
    .VADDR_W (VADDR_W),
    .PADDR_W (PADDR_W),
    .OFS_W   (OFS_W),
    .BASE_W  (BASE_W)
  ) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .baseWrEn    (baseWrEn),
    .baseWrData  (baseWrData),
    .reqVaddr    (reqVaddr),
    .reqKind     (reqKind),
    .memRespData (memRespData),
    .memAddr     (memAddr),
    .rspPaddr    (rspPaddr),
    .rspFault    (rspFault),
    .rspCause    (rspCause)
  );

  assign memReq   = strobe.issueRead;
  assign rspValid = strobe.respond;

endmodule

// File: tb/tb_pt_xlate.sv
`timescale 1ns/1ps
module tb_pt_xlate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic        rspFault;
  logic [1:0]  rspCause;

  int checkCnt = 0;
  int failCnt = 0;
  logic [31:0] curBase = '0;

  always #2 clk = ~clk;

  pt_xlate dut (
    .clk(clk), .rstN(rstN), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqKind(reqKind),
    .memReq(memReq), .memAddr(memAddr), .memRespValid(memRespValid),
    .memRespData(memRespData), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspFault(rspFault), .rspCause(rspCause)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setBase(input logic [31:0] b);
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = b;
    @(negedge clk);
    baseWrEn = 1'b0;
    curBase = b;
  endtask

  // Full translation; lat >= 1 cycles between memReq and memRespValid.
  task automatic doXlate(input string req, input logic [31:0] va, input logic [1:0] kind,
                         input logic [31:0] entry, input int lat,
                         input bit midBase, input logic [31:0] midVal);
    logic [31:0] expAddr;
    logic        expFault;
    logic [1:0]  expCause;
    logic [31:0] expPa;
    logic        perm;
    expAddr = curBase + {va[31:12], 2'b00};
    case (kind)
      2'b00:   perm = entry[30];
      2'b01:   perm = entry[29];
      2'b10:   perm = entry[28];
      default: perm = 1'b0;
    endcase
    if (!entry[31])  begin expFault = 1; expCause = 2'b01; expPa = '0; end
    else if (!perm)  begin expFault = 1; expCause = 2'b10; expPa = '0; end
    else             begin expFault = 0; expCause = 2'b00; expPa = {entry[19:0], va[11:0]}; end

    @(negedge clk);
    chk(reqReady === 1'b1, req, "ready before request", {63'b0, reqReady}, 64'h1);
    reqVaddr = va; reqKind = kind; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(memReq === 1'b1, "R2", "memReq after accept", {63'b0, memReq}, 64'h1);
    chk(memAddr === expAddr, "R2", "entry address", {32'b0, memAddr}, {32'b0, expAddr});
    chk(reqReady === 1'b0, "R8", "ready low in walk", {63'b0, reqReady}, 64'h0);
    for (int i = 0; i < lat; i++) begin
      if (i == 0 && midBase) begin baseWrEn = 1'b1; baseWrData = midVal; end
      @(negedge clk);
      baseWrEn = 1'b0;
      chk(memReq === 1'b0 && reqReady === 1'b0 && rspValid === 1'b0, "R9",
          "waiting for entry", {61'b0, memReq, reqReady, rspValid}, 64'h0);
    end
    if (midBase) curBase = midVal;
    memRespValid = 1'b1; memRespData = entry;
    @(negedge clk);
    memRespValid = 1'b0; memRespData = '0;
    chk(rspValid === 1'b1, "R8", "response valid", {63'b0, rspValid}, 64'h1);
    chk(rspFault === expFault, req, "fault", {63'b0, rspFault}, {63'b0, expFault});
    chk(rspCause === expCause, req, "cause", {62'b0, rspCause}, {62'b0, expCause});
    chk(rspPaddr === expPa, req, "paddr", {32'b0, rspPaddr}, {32'b0, expPa});
    @(negedge clk);
    chk(rspValid === 1'b0 && reqReady === 1'b1, "R8", "response is one pulse",
        {62'b0, rspValid, reqReady}, 64'h1);
  endtask

  task automatic testReset();
    chk(reqReady === 1'b1, "R1", "reset ready", {63'b0, reqReady}, 64'h1);
    chk(rspValid === 1'b0, "R1", "reset rspValid", {63'b0, rspValid}, 64'h0);
    chk(memReq === 1'b0, "R1", "reset memReq", {63'b0, memReq}, 64'h0);
  endtask

  task automatic testLoadStoreFetch();
    setBase(32'h0010_0000);
    // R4 R7: readable entry, load succeeds
    doXlate("R7", 32'h0001_2345, 2'b00, 32'hC000_0ABC, 1, 0, '0);
    // R6: store on read-only page
    doXlate("R6", 32'h0001_2345, 2'b01, 32'hC000_0ABC, 1, 0, '0);
    // R6: store on read/write page succeeds
    doXlate("R6", 32'h0040_0FFF, 2'b01, 32'hE000_1234, 2, 0, '0);
    // R6: fetch on non-executable page
    doXlate("R6", 32'h0040_0000, 2'b10, 32'hE000_1234, 1, 0, '0);
    // R6: fetch on executable-only page succeeds, load there faults
    doXlate("R6", 32'h0040_0010, 2'b10, 32'h9000_0077, 1, 0, '0);
    doXlate("R6", 32'h0040_0010, 2'b00, 32'h9000_0077, 1, 0, '0);
    // R6: reserved kind faults even with all rights
    doXlate("R6", 32'h0000_1000, 2'b11, 32'hF000_0001, 1, 0, '0);
  endtask

  task automatic testAbsent();
    // R5: absent with no rights and with every right
    doXlate("R5", 32'h7FFF_F123, 2'b00, 32'h0000_0042, 1, 0, '0);
    doXlate("R5", 32'h7FFF_F123, 2'b11, 32'h7000_0042, 1, 0, '0);
  endtask

  task automatic testLatencyAndBase();
    // R9: long memory latency
    doXlate("R9", 32'hFFFF_FABC, 2'b00, 32'hC00F_FFFF, 6, 0, '0);
    // R3: new base used by later requests
    setBase(32'h8000_0000);
    doXlate("R3", 32'h0000_3000, 2'b00, 32'hC000_0003, 1, 0, '0);
    // R3: base write mid-walk does not disturb the current walk
    doXlate("R3", 32'h0000_5008, 2'b01, 32'hA000_0055, 3, 1, 32'h0123_4000);
    doXlate("R3", 32'h0000_5008, 2'b01, 32'hA000_0055, 1, 0, '0);
    // R7: all-ones page number and offset
    doXlate("R7", 32'h1234_5FFF, 2'b10, 32'h9FFF_FFFF, 1, 0, '0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLoadStoreFetch();
    testAbsent();
    testLatencyAndBase();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule